// File: doc/BRIEF.md
# Class-Quota Row-Aware Request Picker

This block chooses which pending request in a DRAM controller queue is served next. Every queue slot carries a process tag, a target bank, a target row and an arrival sequence number used as its age. The controller supplies the open-row state of every bank. Software supplies a per-process high-priority mask and a pair of service counts, one for the favoured class and one for the rest. The block issues at most one registered grant per clock. The grant names the chosen slot and reports the class of that slot.

With the priority lever switched off, the picker serves row hits first and then the oldest request. With the lever switched on, a quota decides the class first. A round serves up to the high count of favoured requests and up to the low count of the others. The usual row-hit-then-oldest rule then picks inside the class that is allowed. Loading a larger or smaller count pair makes the lever act more or less strongly. If the class whose turn it is has no work, the other class is served so that the quota never stalls the queue.

The surrounding controller removes a granted slot from the queue before the next clock edge. It also assigns ages that increase with arrival and do not wrap while a slot is pending.

Top module: `prio_mem_sched`

## Requirements
- R1: While reset is asserted, and after reset until some slot is valid, `gnt_valid` is 0.
- R2: If any slot is valid at a clock edge, `gnt_valid` is 1 after that edge. If no slot is valid, `gnt_valid` is 0 after that edge. At most one slot is granted per edge.
- R3: `gnt_idx` names a slot that was valid at the edge that produced the grant. `gnt_hi` is 1 exactly when that slot belonged to the favoured class.
- R4: With `cfg_enable` = 0, a row hit is always chosen over a miss whenever a hit is pending. A slot is a row hit when `bank_open[bank]` = 1 and `bank_row[bank]` equals the slot's row.
- R5: Among candidates with the same hit status, the smallest age wins. Equal ages go to the lower slot index.
- R6: With `cfg_enable` = 1 and both classes pending, a round serves `cfg_hi_quota` favoured grants and then `cfg_lo_quota` other grants. The first grant after the lever is switched on is a favoured one, and it opens a round.
- R7: With `cfg_enable` = 1, if the class whose quota is not yet used up has no pending slot, a pending slot of the other class is granted.
- R8: A new round with both counts reloaded starts after the grant that uses up both counts. It also starts when a grant is made to a class whose count is already used up. Remaining counts carry over idle cycles and queue refills.
- R9: With `cfg_enable` = 1, the choice inside the allowed class follows R4 and R5: row hits first, then smallest age.
- R10: A slot is in the favoured class when `cfg_hi_mask[tag]` = 1, where tag is the slot's process tag.
- R11: Setting `cfg_enable` to 0 discards round progress. The next time the lever is on, R6 applies again from its first grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | DEPTH (16) | Per-slot pending flag |
| req_tag | input | DEPTH x TAG_W (16x3) | Per-slot process tag |
| req_bank | input | DEPTH x BANK_W (16x2) | Per-slot target bank |
| req_row | input | DEPTH x ROW_W (16x8) | Per-slot target row |
| req_age | input | DEPTH x AGE_W (16x8) | Per-slot arrival sequence number, smaller is older |
| bank_open | input | NBANK (4) | Bank has an open row |
| bank_row | input | NBANK x ROW_W (4x8) | Open row of each bank |
| cfg_enable | input | 1 | Priority lever on |
| cfg_hi_mask | input | 2**TAG_W (8) | Favoured-class flag per process tag |
| cfg_hi_quota | input | QUOTA_W (4) | Favoured grants per round |
| cfg_lo_quota | input | QUOTA_W (4) | Other grants per round |
| gnt_valid | output | 1 | A grant is presented this cycle |
| gnt_idx | output | log2(DEPTH) (4) | Granted slot |
| gnt_hi | output | 1 | Granted slot is in the favoured class |

## Verification
With the lever off, the bench loads a mix of hits and misses whose ages are out of slot order. This separates row-hit preference from plain age order, and reaching slot 15 exercises the full index. The same four-slot mix is then replayed with the lever on under a 1:1 count. The two grant orders must differ, which shows the quota acting ahead of the hit rule while the hit rule still picks inside a class. Full queues under 4:3 and 2:1 show how the count pair sets the interleave. A low-class-only load followed by a refill with older low slots shows the fallback and that the counts carry over. Two tags that differ in one mask bit confirm the class lookup.

// File: rtl/sched_pkg.sv
// Shared types for the priority memory scheduler.
// Assumes nothing beyond IEEE 1800-2017.
package sched_pkg;
    // Request class as seen by the quota logic.
    typedef enum logic {
        CLS_LO = 1'b0,
        CLS_HI = 1'b1
    } cls_e;
endpackage

// File: rtl/sched_entry_eval.sv
// Per-slot evaluation: decides whether a slot hits the open row of its
// bank and whether its process tag belongs to the favoured class.
// Assumes bank and open-row inputs are stable within the cycle.
module sched_entry_eval #(
    parameter int TAG_W  = 3,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    localparam int NBANK = 1 << BANK_W,
    localparam int NTAG  = 1 << TAG_W
) (
    input  logic [TAG_W-1:0]            tag,
    input  logic [BANK_W-1:0]           bank,
    input  logic [ROW_W-1:0]            row,
    input  logic [NBANK-1:0]            bank_open,
    input  logic [NBANK-1:0][ROW_W-1:0] bank_row,
    input  logic [NTAG-1:0]             hi_mask,
    output logic                        hit,
    output sched_pkg::cls_e             cls
);
    // Row-hit test and class lookup for one slot.
    always_comb begin
        hit = bank_open[bank] && (bank_row[bank] == row);
        cls = hi_mask[tag] ? sched_pkg::CLS_HI : sched_pkg::CLS_LO;
    end
endmodule

// File: rtl/sched_quota.sv
// Class quota tracker. Holds the remaining favoured and other counts of
// the current round, chooses the class for this cycle and advances the
// counts on every grant. A grant outside the quota (the due class has no
// work) starts a new round; a round also restarts when both counts are
// used up. The counts are cleared while the lever is off.
module sched_quota #(
    parameter int QUOTA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               fire,
    input  logic               has_hi,
    input  logic               has_lo,
    input  logic [QUOTA_W-1:0] hi_quota,
    input  logic [QUOTA_W-1:0] lo_quota,
    output sched_pkg::cls_e    sel_cls
);
    logic [QUOTA_W-1:0] hi_left, lo_left;
    logic [QUOTA_W-1:0] base_hi, base_lo, nxt_hi, nxt_lo;
    logic               pick_hi, in_quota;

    // Class choice for this cycle and the counts after a grant.
    always_comb begin
        if (hi_left != '0 && has_hi)
            pick_hi = 1'b1;
        else if (lo_left != '0 && has_lo)
            pick_hi = 1'b0;
        else
            pick_hi = has_hi;
        in_quota = pick_hi ? (hi_left != '0) : (lo_left != '0);
        base_hi  = in_quota ? hi_left : hi_quota;
        base_lo  = in_quota ? lo_left : lo_quota;
        nxt_hi   = base_hi;
        nxt_lo   = base_lo;
        if (pick_hi && base_hi != '0)
            nxt_hi = base_hi - 1'b1;
        if (!pick_hi && base_lo != '0)
            nxt_lo = base_lo - 1'b1;
        if (nxt_hi == '0 && nxt_lo == '0) begin
            nxt_hi = hi_quota;
            nxt_lo = lo_quota;
        end
        sel_cls = pick_hi ? sched_pkg::CLS_HI : sched_pkg::CLS_LO;
    end

    // Round counters: cleared when the lever is off, advanced per grant.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            hi_left <= '0;
            lo_left <= '0;
        end else if (fire) begin
            hi_left <= nxt_hi;
            lo_left <= nxt_lo;
        end
    end
endmodule

// File: rtl/sched_pick.sv
// Candidate picker: among eligible slots prefers row hits, then the
// smallest age, then the lowest index. Assumes ages do not wrap while
// slots are pending.
module sched_pick #(
    parameter int DEPTH = 16,
    parameter int AGE_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            elig,
    input  logic [DEPTH-1:0]            hit,
    input  logic [DEPTH-1:0][AGE_W-1:0] age,
    output logic                        found,
    output logic [IDX_W-1:0]            idx
);
    logic [DEPTH-1:0] hit_elig, pool;
    logic [AGE_W-1:0] best_age;

    // Restrict to hits when any exist, then scan for the oldest slot.
    always_comb begin
        hit_elig = elig & hit;
        pool     = (|hit_elig) ? hit_elig : elig;
        found    = 1'b0;
        idx      = '0;
        best_age = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (pool[i] && (!found || age[i] < best_age)) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                best_age = age[i];
            end
        end
    end
endmodule

// File: rtl/prio_mem_sched.sv
// Weighted-ratio priority request picker for a DRAM controller queue.
// With the lever on, a class quota selects favoured or other requests
// first; row-hit then oldest picks inside the allowed class. With the
// lever off, row-hit then oldest picks over the whole queue. One
// registered grant per cycle; the queue owner removes the granted slot
// before the next edge.
module prio_mem_sched #(
    parameter int DEPTH   = 16,
    parameter int TAG_W   = 3,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 8,
    parameter int AGE_W   = 8,
    parameter int QUOTA_W = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int NBANK  = 1 << BANK_W,
    localparam int NTAG   = 1 << TAG_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             req_valid,
    input  logic [DEPTH-1:0][TAG_W-1:0]  req_tag,
    input  logic [DEPTH-1:0][BANK_W-1:0] req_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]  req_row,
    input  logic [DEPTH-1:0][AGE_W-1:0]  req_age,
    input  logic [NBANK-1:0]             bank_open,
    input  logic [NBANK-1:0][ROW_W-1:0]  bank_row,
    input  logic                         cfg_enable,
    input  logic [NTAG-1:0]              cfg_hi_mask,
    input  logic [QUOTA_W-1:0]           cfg_hi_quota,
    input  logic [QUOTA_W-1:0]           cfg_lo_quota,
    output logic                         gnt_valid,
    output logic [IDX_W-1:0]             gnt_idx,
    output logic                         gnt_hi
);
    logic [DEPTH-1:0] hit_vec, hi_vec, elig;
    logic             has_hi, has_lo, fire, found;
    logic [IDX_W-1:0] pick_idx;
    sched_pkg::cls_e  sel_cls;

    // One evaluator per queue slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sched_pkg::cls_e slot_cls;
        sched_entry_eval #(
            .TAG_W (TAG_W),
            .BANK_W(BANK_W),
            .ROW_W (ROW_W)
        ) i_eval (
            .tag      (req_tag[g]),
            .bank     (req_bank[g]),
            .row      (req_row[g]),
            .bank_open(bank_open),
            .bank_row (bank_row),
            .hi_mask  (cfg_hi_mask),
            .hit      (hit_vec[g]),
            .cls      (slot_cls)
        );
        assign hi_vec[g] = (slot_cls == sched_pkg::CLS_HI);
    end

    // Pending work per class.
    always_comb begin
        has_hi = |(req_valid & hi_vec);
        has_lo = |(req_valid & ~hi_vec);
        fire   = |req_valid;
    end

    sched_quota #(
        .QUOTA_W(QUOTA_W)
    ) i_quota (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .fire    (fire),
        .has_hi  (has_hi),
        .has_lo  (has_lo),
        .hi_quota(cfg_hi_quota),
        .lo_quota(cfg_lo_quota),
        .sel_cls (sel_cls)
    );

    // Eligible slots: whole queue with the lever off, else the chosen class.
    always_comb begin
        if (!cfg_enable)
            elig = req_valid;
        else if (sel_cls == sched_pkg::CLS_HI)
            elig = req_valid & hi_vec;
        else
            elig = req_valid & ~hi_vec;
    end

    sched_pick #(
        .DEPTH(DEPTH),
        .AGE_W(AGE_W)
    ) i_pick (
        .elig (elig),
        .hit  (hit_vec),
        .age  (req_age),
        .found(found),
        .idx  (pick_idx)
    );

    // Registered grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_idx   <= '0;
            gnt_hi    <= 1'b0;
        end else begin
            gnt_valid <= found;
            gnt_idx   <= pick_idx;
            gnt_hi    <= hi_vec[pick_idx];
        end
    end
endmodule

// File: rtl/prio_mem_sched_chk.sv
// Checker bound to the scheduler: relates each grant to the queue state
// seen at the edge that produced it. Keeps its own record of the last
// cycle's valid slots, their class and their row-hit status.
module prio_mem_sched_chk #(
    parameter int DEPTH   = 16,
    parameter int TAG_W   = 3,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int NBANK  = 1 << BANK_W,
    localparam int NTAG   = 1 << TAG_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [DEPTH-1:0]             req_valid,
    input logic [DEPTH-1:0][TAG_W-1:0]  req_tag,
    input logic [DEPTH-1:0][BANK_W-1:0] req_bank,
    input logic [DEPTH-1:0][ROW_W-1:0]  req_row,
    input logic [NBANK-1:0]             bank_open,
    input logic [NBANK-1:0][ROW_W-1:0]  bank_row,
    input logic                         cfg_enable,
    input logic [NTAG-1:0]              cfg_hi_mask,
    input logic                         gnt_valid,
    input logic [IDX_W-1:0]             gnt_idx,
    input logic                         gnt_hi
);
    logic [DEPTH-1:0] cur_hit, cur_hi;
    logic [DEPTH-1:0] prev_valid, prev_hit, prev_hi;
    logic             prev_en;

    // Independent view of slot hit and class this cycle.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cur_hit[i] = bank_open[req_bank[i]] && bank_row[req_bank[i]] == req_row[i];
            cur_hi[i]  = cfg_hi_mask[req_tag[i]];
        end
    end

    // Snapshot of the queue at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= '0;
            prev_hit   <= '0;
            prev_hi    <= '0;
            prev_en    <= 1'b0;
        end else begin
            prev_valid <= req_valid;
            prev_hit   <= cur_hit;
            prev_hi    <= cur_hi;
            prev_en    <= cfg_enable;
        end
    end

    // R2: pending work yields a grant next cycle.
    a_r2_grant_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |=> gnt_valid);
    // R2: an empty queue yields no grant next cycle.
    a_r2_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_valid) |=> !gnt_valid);
    // R3: the granted slot was pending.
    a_r3_grant_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> prev_valid[gnt_idx]);
    // R10: reported class matches the mask lookup of the granted slot.
    a_r10_class_flag: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt_hi == prev_hi[gnt_idx]));
    // R4: with the lever off a pending hit is never passed over.
    a_r4_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !prev_en && |(prev_valid & prev_hit)) |-> prev_hit[gnt_idx]);
endmodule

bind prio_mem_sched prio_mem_sched_chk #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_tag    (req_tag),
    .req_bank   (req_bank),
    .req_row    (req_row),
    .bank_open  (bank_open),
    .bank_row   (bank_row),
    .cfg_enable (cfg_enable),
    .cfg_hi_mask(cfg_hi_mask),
    .gnt_valid  (gnt_valid),
    .gnt_idx    (gnt_idx),
    .gnt_hi     (gnt_hi)
);

// File: tb/test_prio_mem_sched.sv
// Scoreboard bench: each scenario pushes its expected grant order
// (class*100 + slot) into a queue; the monitor task pops one entry per
// grant, compares, and retires the granted slot from the queue.
module test_prio_mem_sched;
    localparam int DEPTH = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [DEPTH-1:0]       req_valid;
    logic [DEPTH-1:0][2:0]  req_tag;
    logic [DEPTH-1:0][1:0]  req_bank;
    logic [DEPTH-1:0][7:0]  req_row;
    logic [DEPTH-1:0][7:0]  req_age;
    logic [3:0]             bank_open;
    logic [3:0][7:0]        bank_row;
    logic                   cfg_enable;
    logic [7:0]             cfg_hi_mask;
    logic [3:0]             cfg_hi_quota, cfg_lo_quota;
    logic                   gnt_valid;
    logic [3:0]             gnt_idx;
    logic                   gnt_hi;

    int checks = 0;
    int failures = 0;
    int exp_q[$];

    prio_mem_sched i_prio_mem_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
        .bank_open(bank_open), .bank_row(bank_row), .cfg_enable(cfg_enable),
        .cfg_hi_mask(cfg_hi_mask), .cfg_hi_quota(cfg_hi_quota),
        .cfg_lo_quota(cfg_lo_quota), .gnt_valid(gnt_valid),
        .gnt_idx(gnt_idx), .gnt_hi(gnt_hi)
    );

    always #4 clk = ~clk;

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clear_q();
        req_valid = '0; req_tag = '0; req_bank = '0; req_row = '0; req_age = '0;
    endtask

    task automatic put(input int i, input int tag, input int bank, input int row, input int age);
        req_valid[i] = 1'b1;
        req_tag[i]   = 3'(tag);
        req_bank[i]  = 2'(bank);
        req_row[i]   = 8'(row);
        req_age[i]   = 8'(age);
    endtask

    // Monitor: one grant per cycle, compared against the scoreboard.
    task automatic drain(input string rq);
        int guard = 0;
        while (exp_q.size() > 0 && guard < 40) begin
            @(posedge clk); @(negedge clk);
            guard++;
            if (gnt_valid) begin
                check(rq, int'(gnt_hi) * 100 + int'(gnt_idx), exp_q.pop_front());
                req_valid[gnt_idx] = 1'b0;
            end
        end
        if (exp_q.size() > 0) begin
            check(rq, exp_q.size(), 0);
            exp_q.delete();
        end
        @(posedge clk); @(negedge clk);
        check("R2 idle after drain", int'(gnt_valid), 0);
    endtask

    // Lever off for one cycle: discards round progress (R11).
    task automatic fresh_round(input int hq, input int lq, input logic [7:0] mask);
        cfg_enable = 1'b0;
        @(posedge clk); @(negedge clk);
        cfg_hi_quota = 4'(hq); cfg_lo_quota = 4'(lq); cfg_hi_mask = mask;
        cfg_enable = 1'b1;
    endtask

    task automatic expect_seq(input int s[]);
        foreach (s[k]) exp_q.push_back(s[k]);
    endtask

    task automatic load_mix();
        clear_q();
        bank_open = 4'b0100; bank_row = '0; bank_row[2] = 8'd9;
        put(0, 1, 2, 1, 1);
        put(1, 1, 2, 9, 4);
        put(2, 0, 2, 9, 2);
        put(3, 0, 3, 0, 0);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_q();
        bank_open = '0; bank_row = '0;
        cfg_enable = 1'b0; cfg_hi_mask = '0; cfg_hi_quota = 4'd4; cfg_lo_quota = 4'd3;
        repeat (3) @(negedge clk);
        check("R1 reset", int'(gnt_valid), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 idle after reset", int'(gnt_valid), 0);

        // R4/R5 lever off: hits oldest first, then misses oldest first.
        clear_q();
        bank_open = 4'b0001; bank_row[0] = 8'd5;
        put(0, 0, 0, 7, 10);
        put(1, 0, 0, 5, 20);
        put(2, 0, 1, 0, 5);
        put(3, 0, 0, 5, 15);
        expect_seq('{3, 1, 2, 0});
        drain("R4 R5 hit-first");

        // R5 all misses, ages out of slot order, top slot index.
        clear_q();
        bank_open = '0;
        put(4, 0, 0, 0, 30);
        put(5, 0, 0, 0, 3);
        put(9, 0, 0, 0, 12);
        put(15, 0, 0, 0, 1);
        expect_seq('{15, 5, 9, 4});
        drain("R5 oldest");

        // R6 4:3, full queue, all misses.
        fresh_round(4, 3, 8'b0000_0010);
        clear_q();
        for (int i = 0; i < 8; i++) put(i, 1, 0, 0, i);
        for (int i = 8; i < 16; i++) put(i, 2, 0, 0, i);
        expect_seq('{100, 101, 102, 103, 8, 9, 10, 104, 105, 106, 107, 11, 12, 13, 14, 15});
        drain("R6 R8 ratio 4:3");

        // R6 strength: 2:1.
        fresh_round(2, 1, 8'b0000_0010);
        clear_q();
        for (int i = 0; i < 3; i++) put(i, 1, 0, 0, i);
        for (int i = 3; i < 6; i++) put(i, 0, 0, 0, i);
        expect_seq('{100, 101, 3, 102, 4, 5});
        drain("R6 R7 ratio 2:1");

        // R9 lever on 1:1: class first, then hit inside the class.
        fresh_round(1, 1, 8'b0000_0010);
        load_mix();
        expect_seq('{101, 2, 100, 3});
        drain("R9 quota then hit");

        // R4 same mix, lever off: order differs.
        cfg_enable = 1'b0;
        load_mix();
        expect_seq('{2, 101, 3, 100});
        drain("R4 same mix lever off");

        // R7 only other-class work with the lever on 2:2.
        fresh_round(2, 2, 8'b0000_0010);
        clear_q();
        put(6, 0, 0, 0, 1);
        put(7, 0, 0, 0, 2);
        expect_seq('{6, 7});
        drain("R7 fallback");

        // R8 counts persist: favoured slots served first although younger.
        clear_q();
        put(0, 1, 0, 0, 10);
        put(1, 1, 0, 0, 11);
        put(2, 0, 0, 0, 1);
        put(3, 0, 0, 0, 2);
        put(4, 0, 0, 0, 3);
        expect_seq('{100, 101, 2, 3, 4});
        drain("R8 carry-over");

        // R10 mask lookup: tag 5 favoured, tag 4 not.
        fresh_round(1, 1, 8'b0010_0000);
        clear_q();
        put(10, 4, 0, 0, 0);
        put(11, 5, 0, 0, 1);
        expect_seq('{111, 10});
        drain("R10 mask");

        // R11 progress discarded: 1:1 fresh round starts favoured again.
        fresh_round(1, 1, 8'b0000_0010);
        clear_q();
        put(0, 0, 0, 0, 0);
        put(1, 1, 0, 0, 5);
        put(2, 0, 0, 0, 1);
        expect_seq('{101, 0, 2});
        drain("R11 restart");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule